// File: doc/BRIEF.md
# Selectable Periodic Interrupt Generator

This block turns a 256 Hz clock-enable tick, supplied by an upstream prescaler, into a periodic event whose rate software picks through a 3-bit code in an 8-bit control register. Each event sets a sticky flag in the same register. The flag stays set until software writes a zero to it.

An interrupt line follows the flag, but only while an active rate code is loaded. Software can therefore mask the line by parking the code at zero without losing a pending flag. Whenever the rate code changes, the internal tick divider restarts. The first event at the new rate then arrives one full new period after the write.

Top module: `periodic_irq_gen`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), rd_data reads 0x00 and irq_o is low.
- R2: With rate code 0 loaded, no event occurs and the flag is never set, however many ticks arrive.
- R3: Codes 1, 2, 3, 4, 5 and 6 give one event every 1, 4, 16, 64, 128 and 256 ticks (256, 64, 16, 4, 2 and 1 Hz). The flag reads 1 from the clock edge that samples the last tick of a period.
- R4: Code 7 is reserved and behaves exactly like code 0: no events, and irq_o stays low.
- R5: The flag is sticky. It holds without ticks, and a write with bit 7 set leaves it unchanged.
- R6: A write with bit 7 clear clears the flag when no event occurs in the same cycle.
- R7: A write that changes the rate code restarts the divider, and any tick in the same cycle as that write is discarded. The first event comes after a full new period. A write that keeps the same code does not restart the divider.
- R8: An event in the same cycle as a clearing write leaves the flag set.
- R9: irq_o is high exactly when the flag is set and the loaded code is 1 to 6.
- R10: The register layout is: flag in bit 7, rate code in bits 6:4, bits 3:0 read as zero with writes to them ignored. A write loads the rate code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | 256 Hz clock-enable tick, one cycle wide |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Write data: bit 7 clear requests a flag clear, bits 6:4 rate code |
| rd_data | output | 8 | Control register readback |
| irq_o | output | 1 | Periodic interrupt request |

## Verification
The bench measures every rate period to the exact tick, checking the flag one tick before and on the tick that should end the period. An off-by-one divider or a swapped rate code therefore shows up as an early or missing flag.

It switches the rate mid-period and checks the restarted count. It does the same with a tick arriving during the write. A design that kept the old count would fire early, and one that counted the coincident tick would fire one tick early. A rewrite of the same code must not restart the divider, or the flag would come late.

A clear that coincides with an event must leave the flag set; a design that gives the clear priority loses that event. Finally, the flag is kept pending while the code is 0 or 7. This catches an interrupt line that ignores the rate code and a reserved code that still counts.

// File: rtl/prd_pkg.sv
// Package: shared constants and helpers for the periodic interrupt generator.
// Assumes the tick rate is a multiple of 256 so every divisor is an integer.
package prd_pkg;
    localparam int REG_W    = 8;
    localparam int SEL_W    = 3;
    localparam int SEL_LSB  = 4;
    localparam int FLAG_BIT = 7;
    localparam int NUM_SEL  = 1 << SEL_W;

    // Event rate in Hz selected by each code; 0 means disabled.
    function automatic int unsigned sel_rate_hz(input int unsigned code);
        case (code)
            1:       return 256;
            2:       return 64;
            3:       return 16;
            4:       return 4;
            5:       return 2;
            6:       return 1;
            default: return 0;
        endcase
    endfunction

    // True when the code selects a running rate.
    function automatic logic sel_active(input logic [SEL_W-1:0] code);
        return sel_rate_hz(int'(code)) != 0;
    endfunction
endpackage

// File: rtl/prd_ctrl_reg.sv
// Module: holds the rate-select code and flags writes that change it.
// Assumes a single-register interface: every wr_en is a write to this register.
module prd_ctrl_reg
    import prd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    output logic [SEL_W-1:0] sel_q,
    output logic             sel_change
);
    // Purpose: a write whose code differs from the loaded one restarts timing.
    always_comb sel_change = wr_en && (wr_sel != sel_q);

    // Purpose: load the rate code on every write.
    always_ff @(posedge clk) begin
        if (!rst_n)     sel_q <= '0;
        else if (wr_en) sel_q <= wr_sel;
    end

    assert_sel_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> sel_q == $past(wr_sel));
    assert_sel_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(sel_q));
endmodule

// File: rtl/prd_divider.sv
// Module: counts base ticks and emits a one-cycle event at the end of each period.
// Assumes tick_en is a single-cycle enable; restart wins over a coincident tick.
module prd_divider
    import prd_pkg::*;
#(
    parameter int TICK_HZ = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [SEL_W-1:0] sel,
    input  logic             restart,
    output logic             evt
);
    localparam int CNT_W = $clog2(TICK_HZ + 1);

    logic [CNT_W-1:0] div_tbl [NUM_SEL];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] term;
    logic             active;
    logic             hit;

    // Purpose: one period length per code, derived from the tick rate.
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_div
        localparam int unsigned RATE = sel_rate_hz(g);
        localparam int unsigned DIV  = (RATE == 0) ? 1 : TICK_HZ / RATE;
        assign div_tbl[g] = CNT_W'(DIV);
    end

    // Purpose: decode the terminal count and the end-of-period condition.
    always_comb begin
        active = sel_active(sel);
        term   = div_tbl[sel] - CNT_W'(1);
        hit    = (cnt_q == term);
        evt    = tick_en && active && !restart && hit;
    end

    // Purpose: advance on each tick, wrap at the terminal count, clear on restart or off.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (restart || !active) cnt_q <= '0;
        else if (tick_en)            cnt_q <= hit ? '0 : cnt_q + CNT_W'(1);
    end

    assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> cnt_q <= term);
    assert_restart_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> cnt_q == '0);
endmodule

// File: rtl/prd_flag.sv
// Module: sticky periodic flag, set by events and cleared by software writing 0.
// Assumes a set takes priority over a clear in the same cycle.
module prd_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic flag_q
);
    // Purpose: set on event, clear on request, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag_q <= 1'b0;
        else if (evt) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    assert_rise_needs_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(evt));
    assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> !flag_q);
    assert_event_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag_q);
endmodule

// File: rtl/periodic_irq_gen.sv
// Module: top of the selectable periodic interrupt generator.
// Divides a 256 Hz tick by a software-chosen code and raises a sticky flag plus irq.
// Assumes tick_en comes from a prescaler in the same clock domain.
module periodic_irq_gen
    import prd_pkg::*;
#(
    parameter int TICK_HZ = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             irq_o
);
    logic [SEL_W-1:0] sel_q;
    logic             sel_change;
    logic             evt;
    logic             flag_q;
    logic             clr;

    prd_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_data[SEL_LSB +: SEL_W]),
        .sel_q      (sel_q),
        .sel_change (sel_change)
    );

    prd_divider #(.TICK_HZ(TICK_HZ)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .sel     (sel_q),
        .restart (sel_change),
        .evt     (evt)
    );

    // Purpose: a write with the flag bit low requests a clear.
    always_comb clr = wr_en && !wr_data[FLAG_BIT];

    prd_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .clr    (clr),
        .flag_q (flag_q)
    );

    // Purpose: assemble readback and gate the interrupt with the loaded code.
    always_comb begin
        rd_data                      = '0;
        rd_data[FLAG_BIT]            = flag_q;
        rd_data[SEL_LSB +: SEL_W]    = sel_q;
        irq_o                        = flag_q && sel_active(sel_q);
    end

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (rd_data[FLAG_BIT] && rd_data[SEL_LSB +: SEL_W] != 3'd0
                   && rd_data[SEL_LSB +: SEL_W] != 3'd7));
    assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_q) == 3'd0) |-> !$rose(flag_q));
    assert_reserved_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_q) == 3'd7) |-> !$rose(flag_q));
    assert_low_nibble_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[3:0] == 4'h0);
endmodule

// File: tb/sim_periodic_irq_gen.sv
module sim_periodic_irq_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    periodic_irq_gen u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq_o   (irq_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rd_data", int'(rd_data), 0);
        chk("R1 irq", int'(irq_o), 0);
    endtask

    task automatic t_rate(input int code, input int div);
        wr(8'((code << 4)));
        pulse(div - 1);
        chk($sformatf("R3 code %0d before period", code), int'(rd_data[7]), 0);
        pulse(1);
        chk($sformatf("R3 code %0d at period", code), int'(rd_data[7]), 1);
        chk($sformatf("R9 irq code %0d", code), int'(irq_o), 1);
    endtask

    task automatic t_sticky();
        wr(8'h10);
        pulse(1);
        repeat (5) @(negedge clk);
        chk("R5 flag holds", int'(rd_data[7]), 1);
        wr(8'h90);
        chk("R5 write 1 keeps flag", int'(rd_data), 8'h90);
        wr(8'h10);
        chk("R6 write 0 clears", int'(rd_data[7]), 0);
        wr(8'h1F);
        chk("R10 low nibble ignored", int'(rd_data), 8'h10);
    endtask

    task automatic t_race();
        wr(8'h10);
        @(negedge clk); tick_en = 1'b1; wr_en = 1'b1; wr_data = 8'h10;
        @(negedge clk); tick_en = 1'b0; wr_en = 1'b0;
        chk("R8 event beats clear", int'(rd_data[7]), 1);
        wr(8'h10);
        chk("R6 clear after race", int'(rd_data[7]), 0);
    endtask

    task automatic t_restart();
        wr(8'h30);
        pulse(10);
        wr(8'h20);
        pulse(3);
        chk("R7 new period not early", int'(rd_data[7]), 0);
        pulse(1);
        chk("R7 new period full", int'(rd_data[7]), 1);
        wr(8'h20);
        pulse(2);
        wr(8'h20);
        pulse(1);
        chk("R7 same code no restart early", int'(rd_data[7]), 0);
        pulse(1);
        chk("R7 same code no restart", int'(rd_data[7]), 1);
        @(negedge clk); tick_en = 1'b1; wr_en = 1'b1; wr_data = 8'h30;
        @(negedge clk); tick_en = 1'b0; wr_en = 1'b0;
        pulse(15);
        chk("R7 coincident tick dropped", int'(rd_data[7]), 0);
        pulse(1);
        chk("R7 coincident tick period", int'(rd_data[7]), 1);
    endtask

    task automatic t_off();
        wr(8'h00);
        pulse(300);
        chk("R2 code 0 no flag", int'(rd_data[7]), 0);
        wr(8'h70);
        pulse(300);
        chk("R4 code 7 no flag", int'(rd_data[7]), 0);
        chk("R4 code 7 irq", int'(irq_o), 0);
    endtask

    task automatic t_gating();
        wr(8'h10);
        pulse(1);
        chk("R9 irq on", int'(irq_o), 1);
        wr(8'h80);
        chk("R9 code 0 keeps flag", int'(rd_data), 8'h80);
        chk("R9 code 0 masks irq", int'(irq_o), 0);
        wr(8'hF0);
        chk("R4 code 7 masks irq", int'(irq_o), 0);
        wr(8'h90);
        chk("R9 irq returns", int'(irq_o), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rate(1, 1);
        t_rate(2, 4);
        t_rate(3, 16);
        t_rate(4, 64);
        t_rate(5, 128);
        t_rate(6, 256);
        t_sticky();
        t_race();
        t_restart();
        t_off();
        t_gating();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule